// File: doc/BRIEF.md
# Optical Module Status Interrupt Monitor

This block watches the slow status lines of four pluggable optical transceivers. For each port it takes three inputs: a module-absent line, a transmitter-fault line and a receiver loss-of-signal line. The absent line is pulled high when the cage is empty and reads low once a module is fitted. The fault and loss lines are active high. Every line passes through a two-flop synchronizer. Any change of the synchronized level, in either direction, sets a sticky per-port change flag.

The three signal types form three groups. Each group has a status register, a change register that clears when read, and an enable mask. It also drives its own shared active-low interrupt. That interrupt is low while any enabled port of the group has a flag set. A control register drives the active-high per-port transmitter-disable outputs. Software reaches all of this through a small synchronous register port with a one-cycle read latency.

Top module: `optmod_status_mon`

## Requirements
- R1: Status registers at address 0 (absent lines), 1 (fault lines) and 2 (loss lines) hold the synchronized input levels in bits [3:0], bit n for port n. The upper bits read 0. After an input change, the new level is in the synchronized copy after the second rising edge.
- R2: A change of a module-absent input, low-to-high or high-to-low, sets bit n of the change register at address 3. The flag is first visible after the third rising edge following the input change, and it holds until that register is read.
- R3: Fault-line and loss-line changes in either direction set flags in the change registers at addresses 4 and 5. The three groups do not affect each other.
- R4: A read of a change register returns its flags, one cycle later on the read-data port, and clears them at the same edge. A read of any other address leaves every flag unchanged.
- R5: If a new change arrives for a port in the same cycle that its change register is read, that port's flag stays set after the read.
- R6: Enable masks are at addresses 6, 7 and 8, bits [3:0]. They are read/write and reset to 0. A group's interrupt output is low exactly when some port has both its change flag and its enable bit set. A flag whose enable bit is clear is still latched, but it does not drive the interrupt.
- R7: A group's interrupt stays low until its enabled flags are cleared by a read of that group's change register, or until they are masked off. Reads of the other groups' registers do not release it.
- R8: The transmitter-disable outputs follow bits [3:0] of the read/write register at address 9. An output is high (transmitter off) when its bit is 1. The register resets to all ones and changes only on a write.
- R9: After reset all change flags are clear, all enables are 0, all three interrupts are high and read data is 0.
- R10: Writes to addresses 0 to 5 have no effect. Reads of addresses 10 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_abs_i | input | 4 | Per-port module-absent line, low when a module is fitted |
| tx_fault_i | input | 4 | Per-port transmitter-fault line, active high |
| rx_los_i | input | 4 | Per-port receiver loss-of-signal line, active high |
| tx_dis_o | output | 4 | Per-port transmitter-disable, active high |
| abs_irq_n_o | output | 1 | Shared module-absent change interrupt, active low |
| fault_irq_n_o | output | 1 | Shared transmitter-fault change interrupt, active low |
| los_irq_n_o | output | 1 | Shared loss-of-signal change interrupt, active low |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |

## Verification
Two functions can fall in the same cycle: the clear-on-read of a change register and the setting of a flag by a fresh input edge. The bench provokes this by toggling a port whose flag is already set. It then counts exactly two rising edges and issues the read on the third, the edge where the synchronized change is detected. The collision is judged with three reads in a row: the first returns the old flag, the second still shows the flag because it survived the clear, and the third returns zero.

// File: rtl/optmod_pkg.sv
package optmod_pkg;
  localparam int unsigned NGRP   = 3;
  localparam int unsigned ADDR_W = 4;

  localparam int unsigned G_ABS   = 0;
  localparam int unsigned G_FAULT = 1;
  localparam int unsigned G_LOS   = 2;

  localparam int unsigned A_STAT_BASE = 0;
  localparam int unsigned A_CHG_BASE  = 3;
  localparam int unsigned A_EN_BASE   = 6;
  localparam int unsigned A_TXDIS     = 9;
endpackage

// File: rtl/optmod_sync.sv
module optmod_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/optmod_chg_grp.sv
module optmod_chg_grp #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q, flag_q;

  function automatic logic [W-1:0] edge_of(input logic [W-1:0] cur, input logic [W-1:0] old);
    return cur ^ old;
  endfunction

  function automatic logic [W-1:0] flag_next(input logic [W-1:0] f, input logic [W-1:0] c,
                                             input logic clr);
    return (f & ~{W{clr}}) | c;
  endfunction

  optmod_sync #(.W(W), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_i), .q_o(lvl_o)
  );

  assign chg_o = edge_of(lvl_o, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_o;
      flag_q <= flag_next(flag_q, chg_o, rd_clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/optmod_status_mon.sv
module optmod_status_mon #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DW     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORTS-1:0]              mod_abs_i,
  input  logic [NPORTS-1:0]              tx_fault_i,
  input  logic [NPORTS-1:0]              rx_los_i,
  output logic [NPORTS-1:0]              tx_dis_o,
  output logic                           abs_irq_n_o,
  output logic                           fault_irq_n_o,
  output logic                           los_irq_n_o,
  input  logic [optmod_pkg::ADDR_W-1:0]  reg_addr_i,
  input  logic                           reg_wr_i,
  input  logic [DW-1:0]                  reg_wdata_i,
  input  logic                           reg_rd_i,
  output logic [DW-1:0]                  reg_rdata_o
);
  import optmod_pkg::*;

  localparam logic [NPORTS-1:0] ALL_ONE = {NPORTS{1'b1}};

  logic [NGRP-1:0][NPORTS-1:0] raw, lvl, chg, flag, en_q;
  logic [NGRP-1:0]             rd_clr, irq_n;
  logic [NPORTS-1:0]           txdis_q;
  logic [DW-1:0]               rd_mux, rdata_q;

  function automatic logic irq_level(input logic [NPORTS-1:0] f, input logic [NPORTS-1:0] e);
    return ~|(f & e);
  endfunction

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  assign raw[G_ABS]   = mod_abs_i;
  assign raw[G_FAULT] = tx_fault_i;
  assign raw[G_LOS]   = rx_los_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [NPORTS-1:0] IDLE_LVL = (g == G_ABS) ? ALL_ONE : '0;

    assign rd_clr[g] = reg_rd_i && hit(reg_addr_i, A_CHG_BASE + g);

    optmod_chg_grp #(.W(NPORTS), .IDLE(IDLE_LVL)) u_grp (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .rd_clr_i(rd_clr[g]),
      .lvl_o(lvl[g]), .chg_o(chg[g]), .flag_o(flag[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          en_q[g] <= '0;
      else if (reg_wr_i && hit(reg_addr_i, A_EN_BASE + g)) en_q[g] <= reg_wdata_i[NPORTS-1:0];
    end

    assign irq_n[g] = irq_level(flag[g], en_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  txdis_q <= ALL_ONE;
    else if (reg_wr_i && hit(reg_addr_i, A_TXDIS)) txdis_q <= reg_wdata_i[NPORTS-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (hit(reg_addr_i, A_STAT_BASE + g)) rd_mux[NPORTS-1:0] = lvl[g];
      if (hit(reg_addr_i, A_CHG_BASE + g))  rd_mux[NPORTS-1:0] = flag[g];
      if (hit(reg_addr_i, A_EN_BASE + g))   rd_mux[NPORTS-1:0] = en_q[g];
    end
    if (hit(reg_addr_i, A_TXDIS)) rd_mux[NPORTS-1:0] = txdis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o   = rdata_q;
  assign tx_dis_o      = txdis_q;
  assign abs_irq_n_o   = irq_n[G_ABS];
  assign fault_irq_n_o = irq_n[G_FAULT];
  assign los_irq_n_o   = irq_n[G_LOS];
endmodule

// File: rtl/optmod_status_mon_chk.sv
module optmod_status_mon_chk #(
  parameter int unsigned NPORTS = 4
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic [optmod_pkg::NGRP-1:0][NPORTS-1:0]  grp_chg,
  input logic [optmod_pkg::NGRP-1:0][NPORTS-1:0]  grp_flag,
  input logic [optmod_pkg::NGRP-1:0]              grp_rdclr,
  input logic [optmod_pkg::NGRP-1:0]              irq_n,
  input logic                                     wr,
  input logic [NPORTS-1:0]                        tx_dis
);
  for (genvar g = 0; g < optmod_pkg::NGRP; g++) begin : g_chk
    AST_FLAG_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (|grp_chg[g]) |=> ((grp_flag[g] & $past(grp_chg[g])) == $past(grp_chg[g]))); // R5
    AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_rdclr[g] && !(|grp_chg[g])) |=> (grp_flag[g] == '0)); // R4
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_rdclr[g] && !(|grp_chg[g])) |=> $stable(grp_flag[g])); // R2
    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n[g]) |-> ($past(|grp_chg[g]) || $past(wr))); // R6
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n[g]) |-> ($past(grp_rdclr[g]) || $past(wr))); // R7
  end

  AST_TXDIS_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(tx_dis)); // R8
endmodule

bind optmod_status_mon optmod_status_mon_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_chg(chg), .grp_flag(flag), .grp_rdclr(rd_clr),
  .irq_n(irq_n), .wr(reg_wr_i), .tx_dis(tx_dis_o)
);

// File: tb/optmod_status_mon_test.sv
module optmod_status_mon_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][3:0] in_v;
  logic [3:0] tx_dis;
  logic abs_irq_n, fault_irq_n, los_irq_n;
  logic [3:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  optmod_status_mon uut (
    .clk(clk), .rst_n(rst_n), .mod_abs_i(in_v[0]), .tx_fault_i(in_v[1]), .rx_los_i(in_v[2]),
    .tx_dis_o(tx_dis), .abs_irq_n_o(abs_irq_n), .fault_irq_n_o(fault_irq_n),
    .los_irq_n_o(los_irq_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rd_i(rd), .reg_rdata_o(rdata)
  );

  function automatic logic [3:0] idle_of(int g);
    return (g == 0) ? 4'hF : 4'h0;
  endfunction

  function automatic logic [2:0] irqs();
    return {los_irq_n, fault_irq_n, abs_irq_n};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    step(1);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wrreg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step(1);
    wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int g = 0; g < 3; g++) in_v[g] = idle_of(g);
    step(3);
    rst_n = 1'b1;
    step(1);

    // R9 reset state
    check("R9 irqs", 32'(irqs()), 32'h7);
    check("R8 txdis reset", 32'(tx_dis), 32'hF);
    check("R9 rdata", 32'(rdata), 32'h0);
    for (int g = 0; g < 3; g++) begin
      rdreg(4'(3 + g), d); check("R9 chg clear", 32'(d), 32'h0);
      rdreg(4'(6 + g), d); check("R9 enable off", 32'(d), 32'h0);
    end

    // R1 R2 R3 R6 sweep: each group, each port, both directions
    for (int g = 0; g < 3; g++) wrreg(4'(6 + g), 8'h0F);
    for (int g = 0; g < 3; g++) begin
      for (int p = 0; p < 4; p++) begin
        for (int dir = 0; dir < 2; dir++) begin
          in_v[g][p] = ~in_v[g][p];
          step(2);
          check("R2 no flag before third edge", 32'(irqs()), 32'h7);
          step(1);
          check("R3 only own group irq low", 32'(irqs()), 32'(3'h7 & ~(3'b1 << g)));
          rdreg(4'(g), d);
          check("R1 status level", 32'(d), 32'(in_v[g]));
          check("R4 status read keeps irq", 32'(irqs()), 32'(3'h7 & ~(3'b1 << g)));
          rdreg(4'(3 + g), d);
          check("R2 R3 change flag", 32'(d), 32'(4'b1 << p));
          check("R4 read clears irq", 32'(irqs()), 32'h7);
          rdreg(4'(3 + g), d);
          check("R4 flags cleared", 32'(d), 32'h0);
        end
      end
    end

    // R6 R7 masking
    wrreg(4'(6), 8'h04);
    in_v[0][0] = ~in_v[0][0];
    step(3);
    check("R6 masked flag no irq", 32'(abs_irq_n), 32'h1);
    in_v[0][2] = ~in_v[0][2];
    step(3);
    check("R6 enabled flag irq", 32'(abs_irq_n), 32'h0);
    rdreg(4'(4), d);
    check("R7 other group read keeps irq", 32'(abs_irq_n), 32'h0);
    wrreg(4'(6), 8'h00);
    check("R7 masked off releases", 32'(abs_irq_n), 32'h1);
    wrreg(4'(6), 8'h05);
    check("R6 unmask reasserts", 32'(abs_irq_n), 32'h0);
    rdreg(4'(3), d);
    check("R6 masked flag still latched", 32'(d), 32'h5);
    check("R7 own read releases", 32'(abs_irq_n), 32'h1);
    in_v[0] = idle_of(0);
    step(3);
    rdreg(4'(3), d);
    check("R2 restore flags", 32'(d), 32'h5);

    // R5 collision of clear-on-read with new change
    wrreg(4'(6), 8'h0F);
    in_v[0][1] = ~in_v[0][1];
    step(3);
    in_v[0][1] = ~in_v[0][1];
    step(2);
    rdreg(4'(3), d);
    check("R5 first read old flag", 32'(d), 32'h2);
    check("R5 irq still low", 32'(abs_irq_n), 32'h0);
    rdreg(4'(3), d);
    check("R5 flag survived clear", 32'(d), 32'h2);
    rdreg(4'(3), d);
    check("R5 third read clear", 32'(d), 32'h0);

    // R8 tx disable sweep
    for (int v = 0; v < 16; v++) begin
      wrreg(4'(9), 8'(v));
      check("R8 txdis out", 32'(tx_dis), 32'(v));
      rdreg(4'(9), d);
      check("R8 txdis readback", 32'(d), 32'(v));
    end

    // R10 writes to read-only addresses ignored, unmapped reads zero
    for (int a = 0; a < 6; a++) wrreg(4'(a), 8'hFF);
    check("R10 irq unaffected", 32'(irqs()), 32'h7);
    for (int g = 0; g < 3; g++) begin
      rdreg(4'(g), d);     check("R10 status unchanged", 32'(d), 32'(idle_of(g)));
      rdreg(4'(3 + g), d); check("R10 chg unchanged", 32'(d), 32'h0);
    end
    for (int a = 10; a < 16; a++) begin
      rdreg(4'(a), d);
      check("R10 unmapped read", 32'(d), 32'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule